// File: doc/BRIEF.md
# Four-Channel FIFO Bank with Gated Interrupts

This block collects 32-bit words from a producer into four independent FIFO channels and lets a host drain them over a small word-addressed register bus. A producer offers one word per cycle on a push port, tagged with a channel number. The host pops a channel by reading that channel's data address. Each channel also has a control word that shows its fill count, EMPTY, a sticky OVERFLOW flag and a per-channel interrupt enable.

A shared host-control register holds three flags: a global FIFO interrupt enable, a reset-output release and a host-event interrupt enable. A flag changes only when a write also sets that flag's gate bit, so software can touch one flag without reading the register first. A status register shows which interrupt sources are pending. The usual service loop is: clear the global FIFO enable, drain every channel until EMPTY, then set the enable again.

Top module: `fifo_bank`

Word addresses: 0x0 to 0x3 are the channel data ports, 0x4 to 0x7 are the channel control words, 0x8 is host control, 0x9 is global status, and every other address reads as zero.

## Requirements
- R1: After reset all four channels are empty, so each control word reads 0x20. Host control reads 0, status reads 0, `irq` is low and `reset_out_n` is low (asserted).
- R2: Control word layout is bits [4:0] count (0 to 16), bit 5 EMPTY, bit 6 OVERFLOW and bit 7 interrupt enable. A full channel reads count 16, so bit 4 is the FULL bit. Words leave a channel in the order they were pushed.
- R3: A bus read of a channel's data address returns the oldest word and pops it. A read of an empty channel returns 0 and leaves the count unchanged.
- R4: A push into a full channel is dropped and sets OVERFLOW. OVERFLOW then stays set until a control-word write has bit 6 at 0. A control write with bit 6 at 1 leaves OVERFLOW as it is. A control write loads bit 7 as the interrupt enable.
- R5: Channels are independent. A push or pop on one channel changes no other channel.
- R6: Host control flags are in bits [2:0], with the gate for flag i in bit 16+i. A flag takes the written flag value only when its gate bit is 1 in the same write. A write with the gate set and the flag clear clears the flag. A write with both set sets it. A write with the gate clear leaves the flag alone. Reads show the flags in [2:0] and return 0 in the gate bits.
- R7: `reset_out_n` follows host-control flag 1: 1 means the reset is released, 0 means it is asserted.
- R8: A channel requests service while its enable is set and it is not empty. Status bit 0 is the OR of all channel requests and does not depend on the global enable.
- R9: `irq` is high exactly when (flag 0 and status bit 0) or (flag 2 and status bit 1).
- R10: A pulse on `hc_event` sets status bit 1, which stays set until a host-control write has gate bit 18 set.
- R11: A push and a pop on the same full channel in the same cycle both take effect. The count stays 16 and OVERFLOW stays clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Word address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; pops on data addresses |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed word (combinational) |
| push_valid | input | 1 | Producer push strobe |
| push_chan | input | 2 | Target channel of the push |
| push_data | input | 32 | Word to push |
| hc_event | input | 1 | Host-event interrupt source pulse |
| irq | output | 1 | Combined interrupt request |
| reset_out_n | output | 1 | Active-low reset output |

## Verification
The assertions assume that `bus_rd` and `bus_wr` are never high in the same cycle. They also assume that every push names a channel that exists. A pop is only defined for a read strobe, and a concurrent write would bypass the control-word decode the properties rely on. The bench drives each bus access as one isolated strobe cycle, with inputs changed on the falling edge. It issues pushes only to channels 0 to 3, and it raises a push together with a read only in the one deliberate same-cycle case of R11.

// File: rtl/fifo_bank_pkg.sv
`timescale 1ns/1ps
package fifo_bank_pkg;
  // Address regions, selected by bus_addr[3:2]
  localparam logic [1:0] REG_DATA = 2'd0;
  localparam logic [1:0] REG_CTRL = 2'd1;
  localparam logic [1:0] REG_SYS  = 2'd2;
  // Low address bits inside the system region
  localparam logic [1:0] SYS_HOSTCTL = 2'd0;
  localparam logic [1:0] SYS_STATUS  = 2'd1;
  // Host-control flag indices
  localparam int HF_FIFO_EN = 0;
  localparam int HF_RST_REL = 1;
  localparam int HF_HC_EN   = 2;
  localparam int HF_COUNT   = 3;
  localparam int GATE_OFS   = 16;
endpackage

// File: rtl/fifo_chan.sv
`timescale 1ns/1ps
module fifo_chan #(
  parameter int DW    = 32,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_en,
  input  logic [DW-1:0] push_data,
  input  logic          pop_en,
  input  logic          ctrl_wr,
  input  logic          ctrl_ie,
  input  logic          ctrl_ovf_keep,
  output logic [DW-1:0] head,
  output logic [LW-1:0] level,
  output logic          empty,
  output logic          ovf,
  output logic          ie,
  output logic          req
);
  localparam logic [LW-1:0] FULL_CNT = LW'(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [LW-1:0] cnt_q, cnt_d;
  logic          ovf_q, ovf_d, ie_q, ie_d;
  logic          is_empty, is_full, do_pop, do_push, ovf_evt;

  // next-state
  always_comb begin
    is_empty = (cnt_q == '0);
    is_full  = (cnt_q == FULL_CNT);
    do_pop   = pop_en & ~is_empty;
    do_push  = push_en & (~is_full | do_pop);
    ovf_evt  = push_en & is_full & ~do_pop;
    wp_d     = wp_q + AW'(do_push);
    rp_d     = rp_q + AW'(do_pop);
    cnt_d    = cnt_q + LW'(do_push) - LW'(do_pop);
    ie_d     = ctrl_wr ? ctrl_ie : ie_q;
    if (ovf_evt)
      ovf_d = 1'b1;
    else if (ctrl_wr && !ctrl_ovf_keep)
      ovf_d = 1'b0;
    else
      ovf_d = ovf_q;
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
      ie_q  <= 1'b0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
      ie_q  <= ie_d;
    end
  end

  // storage, clock-enabled by an accepted push
  always_ff @(posedge clk) begin
    if (do_push)
      mem[wp_q] <= push_data;
  end

  assign head  = is_empty ? '0 : mem[rp_q];
  assign level = cnt_q;
  assign empty = is_empty;
  assign ovf   = ovf_q;
  assign ie    = ie_q;
  assign req   = ie_q & ~is_empty;

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL_CNT); // R2
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (push_en && is_full && !pop_en) |=> (cnt_q == FULL_CNT && ovf_q)); // R4
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !ctrl_wr) |=> ovf_q); // R4
  AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_en && is_empty && !push_en) |=> (cnt_q == '0)); // R3
  AST_FULL_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    (push_en && pop_en && is_full && !ovf_q && !ctrl_wr) |=> (cnt_q == FULL_CNT && !ovf_q)); // R11
endmodule

// File: rtl/fifo_hostctl.sv
`timescale 1ns/1ps
module fifo_hostctl
  import fifo_bank_pkg::*;
#(
  parameter int NF = HF_COUNT,
  parameter int GO = GATE_OFS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [31:0]   wdata,
  input  logic          hc_event,
  output logic [NF-1:0] flags,
  output logic          hc_pend
);
  logic [NF-1:0] flag_q, flag_d;
  logic          pend_q, pend_d;

  // one gate/flag pair per flag
  for (genvar i = 0; i < NF; i++) begin : g_pair
    always_comb begin
      flag_d[i] = (wr && wdata[GO+i]) ? wdata[i] : flag_q[i];
    end
  end

  always_comb begin
    if (hc_event)
      pend_d = 1'b1;
    else if (wr && wdata[GO+HF_HC_EN])
      pend_d = 1'b0;
    else
      pend_d = pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      pend_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
      pend_q <= pend_d;
    end
  end

  assign flags   = flag_q;
  assign hc_pend = pend_q;

  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(flag_q)); // R6
  AST_UNGATED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !wdata[GO+HF_RST_REL]) |=> $stable(flag_q[HF_RST_REL])); // R6
  AST_HC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !(wr && wdata[GO+HF_HC_EN])) |=> pend_q); // R10
  AST_HC_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    hc_event |=> pend_q); // R10
endmodule

// File: rtl/fifo_bank.sv
`timescale 1ns/1ps
module fifo_bank
  import fifo_bank_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DW     = 32,
  parameter int DEPTH  = 16,
  localparam int CW    = $clog2(NUM_CH),
  localparam int LW    = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  input  logic          push_valid,
  input  logic [CW-1:0] push_chan,
  input  logic [DW-1:0] push_data,
  input  logic          hc_event,
  output logic          irq,
  output logic          reset_out_n
);
  localparam int EMPTY_B = LW;
  localparam int OVF_B   = LW + 1;
  localparam int IE_B    = LW + 2;

  logic [DW-1:0]       head  [NUM_CH];
  logic [LW-1:0]       level [NUM_CH];
  logic [NUM_CH-1:0]   ch_empty, ch_ovf, ch_ie, ch_req;
  logic [HF_COUNT-1:0] hflags;
  logic                hc_pend, fifo_pend;
  logic [1:0]          region;
  logic [1:0]          sub;

  assign region = bus_addr[3:2];
  assign sub    = bus_addr[1:0];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic sel;
    assign sel = (sub == 2'(c));
    fifo_chan #(.DW(DW), .DEPTH(DEPTH)) u_ch (
      .clk          (clk),
      .rst_n        (rst_n),
      .push_en      (push_valid && push_chan == CW'(c)),
      .push_data    (push_data),
      .pop_en       (bus_rd && region == REG_DATA && sel),
      .ctrl_wr      (bus_wr && region == REG_CTRL && sel),
      .ctrl_ie      (bus_wdata[IE_B]),
      .ctrl_ovf_keep(bus_wdata[OVF_B]),
      .head         (head[c]),
      .level        (level[c]),
      .empty        (ch_empty[c]),
      .ovf          (ch_ovf[c]),
      .ie           (ch_ie[c]),
      .req          (ch_req[c])
    );
  end

  fifo_hostctl u_hc (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (bus_wr && region == REG_SYS && sub == SYS_HOSTCTL),
    .wdata   (bus_wdata),
    .hc_event(hc_event),
    .flags   (hflags),
    .hc_pend (hc_pend)
  );

  assign fifo_pend   = |ch_req;
  assign irq         = (hflags[HF_FIFO_EN] & fifo_pend) | (hflags[HF_HC_EN] & hc_pend);
  assign reset_out_n = hflags[HF_RST_REL];

  // read multiplexer
  always_comb begin
    bus_rdata = '0;
    unique case (region)
      REG_DATA: if (int'(sub) < NUM_CH) bus_rdata = 32'(head[sub]);
      REG_CTRL: if (int'(sub) < NUM_CH) begin
        bus_rdata[LW-1:0] = level[sub];
        bus_rdata[EMPTY_B] = ch_empty[sub];
        bus_rdata[OVF_B]   = ch_ovf[sub];
        bus_rdata[IE_B]    = ch_ie[sub];
      end
      REG_SYS: begin
        if (sub == SYS_HOSTCTL) bus_rdata[HF_COUNT-1:0] = hflags;
        else if (sub == SYS_STATUS) bus_rdata[1:0] = {hc_pend, fifo_pend};
      end
      default: bus_rdata = '0;
    endcase
  end

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (!hflags[HF_FIFO_EN] && !hflags[HF_HC_EN]) |-> !irq); // R9
  AST_REQ_NEEDS_IE: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_ie == '0) |-> !fifo_pend); // R8
  AST_BUS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_wr)); // R3
endmodule

// File: tb/fifo_bank_test.sv
`timescale 1ns/1ps
module fifo_bank_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  bus_addr;
  logic        bus_wr, bus_rd;
  logic [31:0] bus_wdata, bus_rdata;
  logic        push_valid;
  logic [1:0]  push_chan;
  logic [31:0] push_data;
  logic        hc_event, irq, reset_out_n;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  fifo_bank uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .push_valid(push_valid), .push_chan(push_chan), .push_data(push_data),
    .hc_event(hc_event), .irq(irq), .reset_out_n(reset_out_n)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic push(input logic [1:0] ch, input logic [31:0] d);
    @(negedge clk);
    push_valid = 1'b1; push_chan = ch; push_data = d;
    @(negedge clk);
    push_valid = 1'b0;
  endtask

  task automatic pins(output logic i, output logic r);
    @(negedge clk);
    #1 i = irq; r = reset_out_n;
  endtask

  task automatic t_reset;
    logic [31:0] v; logic i, r;
    for (int c = 0; c < 4; c++) begin
      rd(4'(4 + c), v); chk("R1 ctrl after reset", v, 32'h20);
    end
    rd(4'h8, v); chk("R1 hostctl after reset", v, 0);
    rd(4'h9, v); chk("R1 status after reset", v, 0);
    pins(i, r);
    chk("R1 irq low", {31'b0, i}, 0);
    chk("R1 reset_out_n low", {31'b0, r}, 0);
  endtask

  task automatic t_fill_drain;
    logic [31:0] v;
    for (int k = 0; k < 16; k++) push(2'd1, 32'h100 + 32'(k));
    rd(4'h5, v); chk("R2 full reads count 16", v, 32'h10);
    push(2'd1, 32'hDEAD);
    rd(4'h5, v); chk("R4 overflow on full push", v, 32'h50);
    for (int k = 0; k < 16; k++) begin
      rd(4'h1, v); chk("R2 pop order", v, 32'h100 + 32'(k));
    end
    rd(4'h5, v); chk("R4 overflow sticky after drain", v, 32'h60);
    rd(4'h1, v); chk("R3 empty read returns zero", v, 0);
    rd(4'h5, v); chk("R3 empty read keeps count", v, 32'h60);
    wr(4'h5, 32'h40);
    rd(4'h5, v); chk("R4 write with bit6 keeps overflow", v, 32'h60);
    wr(4'h5, 32'h0);
    rd(4'h5, v); chk("R4 write clears overflow", v, 32'h20);
  endtask

  task automatic t_indep;
    logic [31:0] v;
    push(2'd0, 32'hA0);
    push(2'd2, 32'hC2);
    rd(4'h4, v); chk("R5 ch0 count 1", v, 32'h01);
    rd(4'h6, v); chk("R5 ch2 count 1", v, 32'h01);
    rd(4'h7, v); chk("R5 ch3 untouched", v, 32'h20);
    rd(4'h5, v); chk("R5 ch1 untouched", v, 32'h20);
  endtask

  task automatic t_hostctl;
    logic [31:0] v; logic i, r;
    wr(4'h8, 32'h0000_0001);
    rd(4'h8, v); chk("R6 flag without gate ignored", v, 0);
    wr(4'h8, 32'h0002_0002);
    rd(4'h8, v); chk("R6 gate plus flag sets", v, 32'h2);
    pins(i, r); chk("R7 reset released", {31'b0, r}, 1);
    wr(4'h8, 32'h0001_0001);
    rd(4'h8, v); chk("R6 other flag unchanged", v, 32'h3);
    wr(4'h8, 32'h0002_0000);
    rd(4'h8, v); chk("R6 gate alone clears", v, 32'h1);
    pins(i, r); chk("R7 reset asserted again", {31'b0, r}, 0);
  endtask

  task automatic t_irq;
    logic [31:0] v; logic i, r;
    pins(i, r); chk("R9 no irq without channel enable", {31'b0, i}, 0);
    wr(4'h4, 32'h80);
    pins(i, r); chk("R9 irq with global and channel enable", {31'b0, i}, 1);
    rd(4'h9, v); chk("R8 fifo pending", v, 32'h1);
    wr(4'h8, 32'h0001_0000);
    pins(i, r); chk("R9 irq masked by global clear", {31'b0, i}, 0);
    rd(4'h9, v); chk("R8 pending independent of global", v, 32'h1);
    rd(4'h0, v); chk("R3 drain ch0", v, 32'hA0);
    rd(4'h9, v); chk("R8 pending clears when empty", v, 0);
    wr(4'h8, 32'h0001_0001);
    pins(i, r); chk("R9 rearm with nothing pending", {31'b0, i}, 0);
    push(2'd0, 32'hA1);
    pins(i, r); chk("R9 new data raises irq", {31'b0, i}, 1);
    rd(4'h0, v); chk("R2 ch0 data", v, 32'hA1);
    pins(i, r); chk("R8 ch2 without enable no irq", {31'b0, i}, 0);
    rd(4'h2, v); chk("R5 ch2 data", v, 32'hC2);
    wr(4'h4, 32'h0);
    rd(4'h4, v); chk("R4 enable cleared by write", v, 32'h20);
  endtask

  task automatic t_hc;
    logic [31:0] v; logic i, r;
    @(negedge clk); hc_event = 1'b1;
    @(negedge clk); hc_event = 1'b0;
    rd(4'h9, v); chk("R10 event pending", v, 32'h2);
    pins(i, r); chk("R9 event without enable no irq", {31'b0, i}, 0);
    wr(4'h8, 32'h0004_0004);
    rd(4'h9, v); chk("R10 gate write clears pending", v, 0);
    @(negedge clk); hc_event = 1'b1;
    @(negedge clk); hc_event = 1'b0;
    pins(i, r); chk("R9 event irq", {31'b0, i}, 1);
    wr(4'h8, 32'h0004_0000);
    rd(4'h9, v); chk("R10 cleared", v, 0);
    rd(4'h8, v); chk("R6 hc enable cleared", v, 32'h1);
    pins(i, r); chk("R9 irq low after ack", {31'b0, i}, 0);
  endtask

  task automatic t_simul;
    logic [31:0] v;
    for (int k = 0; k < 16; k++) push(2'd3, 32'h300 + 32'(k));
    @(negedge clk);
    push_valid = 1'b1; push_chan = 2'd3; push_data = 32'h3FF;
    bus_addr = 4'h3; bus_rd = 1'b1;
    #1 v = bus_rdata;
    @(negedge clk);
    push_valid = 1'b0; bus_rd = 1'b0;
    chk("R11 pop returns oldest", v, 32'h300);
    rd(4'h7, v); chk("R11 count stays 16, no overflow", v, 32'h10);
    for (int k = 1; k < 16; k++) begin
      rd(4'h3, v); chk("R11 order after concurrent", v, 32'h300 + 32'(k));
    end
    rd(4'h3, v); chk("R11 pushed word kept", v, 32'h3FF);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_rd = 1'b0; bus_wdata = '0;
    push_valid = 1'b0; push_chan = '0; push_data = '0; hc_event = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_fill_drain;
    t_indep;
    t_hostctl;
    t_irq;
    t_hc;
    t_simul;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule